// File: doc/BRIEF.md
# Sign-Folding Gray Byte Codec

This block sits on the data path between a cache and external memory. It makes the bits stored in memory toggle less often when small signed values change sign, and the processor side never sees the difference. The write path takes a 64-bit two's-complement word and treats each byte as its own signed 8-bit number. It moves the byte's sign into bit 0 and Gray-codes the magnitude into bits 7:1. A non-negative byte uses its own value as the magnitude. A negative byte uses its bitwise inverse. Small values of either sign therefore give codes with few set bits, and a word that flips between +1 and -1 changes only a few bits per lane.

The read path applies the exact inverse. Bit 0 gives the sign. Bits 7:1 pass through a prefix-XOR chain that turns Gray code back into binary, and the result is inverted when the sign bit is set. Each path has its own per-byte enables, a valid/ready handshake on its input and on its output, and a single register stage. A byte whose enable is clear goes through unchanged.

Top module: `byte_fold_codec`

## Requirements
- R1: On the write path, a byte x with bit 7 clear becomes {gray(x)[6:0], 0}, where gray(y) = y ^ (y >> 1). So 00→00, 01→02, 02→06 and 03→04.
- R2: On the write path, a byte x with bit 7 set becomes {gray(~x)[6:0], 1}, so FF→01, FE→03, FD→07 and FC→05. Bit 0 of an enabled output lane always equals bit 7 of the input byte.
- R3: The read path inverts the write transform for all 256 byte values: decode(encode(x)) = x. A word sent through both paths in turn returns unchanged.
- R4: Lane i covers data bits [8i+7:8i] and is enabled by enable bit i. Each lane is transformed on its own, without reference to any other lane.
- R5: A lane whose enable bit is 0 leaves its byte unchanged, and the output enable bit for that lane is also 0. Output enables always equal the enables accepted with the word.
- R6: A word accepted on an input (valid and ready both high at a clock edge) is presented on the matching output with valid high from the next clock edge on.
- R7: While an output has valid high and ready low, its data and enables stay stable and valid stays high. Each accepted word leaves exactly once: no word is lost and none is repeated.
- R8: An input's ready is high whenever its stage is empty or the output ready is high, and low when the stage holds a word that the output is not taking.
- R9: After reset, both output valids are low and both input readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_in_valid | input | 1 | Write path: plain word offered |
| wr_in_ready | output | 1 | Write path: stage can accept a word |
| wr_in_data | input | 64 | Write path: two's-complement word |
| wr_in_be | input | 8 | Write path: per-byte enables |
| wr_out_valid | output | 1 | Write path: encoded word available |
| wr_out_ready | input | 1 | Write path: memory side takes the word |
| wr_out_data | output | 64 | Write path: folded Gray-coded word |
| wr_out_be | output | 8 | Write path: enables forwarded with the word |
| rd_in_valid | input | 1 | Read path: coded word offered |
| rd_in_ready | output | 1 | Read path: stage can accept a word |
| rd_in_data | input | 64 | Read path: coded word from memory |
| rd_in_be | input | 8 | Read path: per-byte enables |
| rd_out_valid | output | 1 | Read path: decoded word available |
| rd_out_ready | input | 1 | Read path: cache side takes the word |
| rd_out_data | output | 64 | Read path: restored two's-complement word |
| rd_out_be | output | 8 | Read path: enables forwarded with the word |

## Verification
The bench sweeps every byte value through every lane on both paths and also checks the eight literal mappings. An off-by-one in the Gray shift, or a wrong choice between the value and its inverse for negative bytes, shows up as a code mismatch, most visibly around 7F/80 and around 00/FF. Random enable masks catch a lane that transforms its byte while disabled, as well as a swapped lane index. A chained run of both paths under random backpressure catches a stage that overwrites a held word or lets the same word out twice, which would show up as a scoreboard mismatch or a count that never completes.

// File: rtl/byte_fold_pkg.sv
package byte_fold_pkg;

  localparam int unsigned LANE_W = 8;

  // Sign to bit 0, Gray-coded magnitude (value or its inverse) to bits 7:1
  function automatic logic [LANE_W-1:0] fold_encode(input logic [LANE_W-1:0] x);
    logic [LANE_W-1:0] mag;
    logic [LANE_W-1:0] gry;
    mag = x[LANE_W-1] ? ~x : x;
    gry = mag ^ (mag >> 1);
    return {gry[LANE_W-2:0], x[LANE_W-1]};
  endfunction

  // Prefix-XOR Gray-to-binary on bits 7:1, then conditional inversion
  function automatic logic [LANE_W-1:0] fold_decode(input logic [LANE_W-1:0] c);
    logic [LANE_W-1:0] gry;
    logic [LANE_W-1:0] bin;
    gry = {1'b0, c[LANE_W-1:1]};
    bin[LANE_W-1] = gry[LANE_W-1];
    for (int k = LANE_W-2; k >= 0; k--) begin
      bin[k] = bin[k+1] ^ gry[k];
    end
    return c[0] ? ~bin : bin;
  endfunction

endpackage

// File: rtl/fold_lane.sv
module fold_lane
  import byte_fold_pkg::*;
#(
  parameter bit DECODE = 1'b0
) (
  input  logic [LANE_W-1:0] lane_in,
  input  logic              lane_en,
  output logic [LANE_W-1:0] lane_out
);

  logic [LANE_W-1:0] xform;

  generate
    if (DECODE) begin : g_dec
      always_comb xform = fold_decode(lane_in);
    end else begin : g_enc
      always_comb xform = fold_encode(lane_in);
    end
  endgenerate

  always_comb lane_out = lane_en ? xform : lane_in;

endmodule

// File: rtl/stage_reg.sv
module stage_reg #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [BE_W-1:0]   in_be,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [BE_W-1:0]   out_be
);

  logic              full_q,  full_d;
  logic [DATA_W-1:0] data_q;
  logic [BE_W-1:0]   be_q;
  logic              load_en;

  always_comb begin
    in_ready = !full_q || out_ready;
    load_en  = in_valid && in_ready;
    full_d   = full_q;
    if (load_en) begin
      full_d = 1'b1;
    end else if (out_ready) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      data_q <= in_data;
      be_q   <= in_be;
    end
  end

  assign out_valid = full_q;
  assign out_data  = data_q;
  assign out_be    = be_q;

endmodule

// File: rtl/fold_path.sv
module fold_path
  import byte_fold_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter bit          DECODE = 1'b0,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LANES-1:0]  in_be,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [LANES-1:0]  out_be
);

  logic [DATA_W-1:0] xf_data;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    fold_lane #(.DECODE(DECODE)) u_lane (
      .lane_in (in_data[i*LANE_W +: LANE_W]),
      .lane_en (in_be[i]),
      .lane_out(xf_data[i*LANE_W +: LANE_W])
    );
  end

  stage_reg #(.DATA_W(DATA_W), .BE_W(LANES)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (xf_data),
    .in_be    (in_be),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_be   (out_be)
  );

endmodule

// File: rtl/byte_fold_codec.sv
module byte_fold_codec
  import byte_fold_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_in_valid,
  output logic              wr_in_ready,
  input  logic [DATA_W-1:0] wr_in_data,
  input  logic [LANES-1:0]  wr_in_be,
  output logic              wr_out_valid,
  input  logic              wr_out_ready,
  output logic [DATA_W-1:0] wr_out_data,
  output logic [LANES-1:0]  wr_out_be,
  input  logic              rd_in_valid,
  output logic              rd_in_ready,
  input  logic [DATA_W-1:0] rd_in_data,
  input  logic [LANES-1:0]  rd_in_be,
  output logic              rd_out_valid,
  input  logic              rd_out_ready,
  output logic [DATA_W-1:0] rd_out_data,
  output logic [LANES-1:0]  rd_out_be
);

  if (DATA_W % LANE_W != 0 || DATA_W == 0) begin : g_bad_width
    $error("byte_fold_codec: DATA_W must be a nonzero multiple of 8");
  end

  fold_path #(.DATA_W(DATA_W), .DECODE(1'b0)) u_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (wr_in_valid),
    .in_ready (wr_in_ready),
    .in_data  (wr_in_data),
    .in_be    (wr_in_be),
    .out_valid(wr_out_valid),
    .out_ready(wr_out_ready),
    .out_data (wr_out_data),
    .out_be   (wr_out_be)
  );

  fold_path #(.DATA_W(DATA_W), .DECODE(1'b1)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (rd_in_valid),
    .in_ready (rd_in_ready),
    .in_data  (rd_in_data),
    .in_be    (rd_in_be),
    .out_valid(rd_out_valid),
    .out_ready(rd_out_ready),
    .out_data (rd_out_data),
    .out_be   (rd_out_be)
  );

endmodule

// File: rtl/byte_fold_codec_checker.sv
module byte_fold_codec_checker #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_in_valid,
  input logic              wr_in_ready,
  input logic [DATA_W-1:0] wr_in_data,
  input logic [LANES-1:0]  wr_in_be,
  input logic              wr_out_valid,
  input logic              wr_out_ready,
  input logic [DATA_W-1:0] wr_out_data,
  input logic [LANES-1:0]  wr_out_be,
  input logic              rd_in_valid,
  input logic              rd_in_ready,
  input logic              rd_out_valid,
  input logic              rd_out_ready,
  input logic [DATA_W-1:0] rd_out_data,
  input logic [LANES-1:0]  rd_out_be
);

  a_r7_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out_valid && !wr_out_ready |=> wr_out_valid && $stable(wr_out_data) && $stable(wr_out_be));

  a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out_valid && !rd_out_ready |=> rd_out_valid && $stable(rd_out_data) && $stable(rd_out_be));

  a_r8_wr_ready_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_out_valid |-> wr_in_ready);

  a_r8_rd_ready_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_out_valid |-> rd_in_ready);

  a_r6_wr_fill: assert property (@(posedge clk) disable iff (!rst_n)
    wr_in_valid && wr_in_ready |=> wr_out_valid);

  a_r6_rd_fill: assert property (@(posedge clk) disable iff (!rst_n)
    rd_in_valid && rd_in_ready |=> rd_out_valid);

  for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
    a_r5_wr_pass: assert property (@(posedge clk) disable iff (!rst_n)
      wr_in_valid && wr_in_ready && !wr_in_be[i] |=>
        wr_out_data[i*8 +: 8] == $past(wr_in_data[i*8 +: 8]) && !wr_out_be[i]);

    a_r2_wr_sign_lsb: assert property (@(posedge clk) disable iff (!rst_n)
      wr_in_valid && wr_in_ready && wr_in_be[i] |=>
        wr_out_data[i*8] == $past(wr_in_data[i*8+7]) && wr_out_be[i]);
  end

endmodule

bind byte_fold_codec byte_fold_codec_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_in_valid (wr_in_valid),
  .wr_in_ready (wr_in_ready),
  .wr_in_data  (wr_in_data),
  .wr_in_be    (wr_in_be),
  .wr_out_valid(wr_out_valid),
  .wr_out_ready(wr_out_ready),
  .wr_out_data (wr_out_data),
  .wr_out_be   (wr_out_be),
  .rd_in_valid (rd_in_valid),
  .rd_in_ready (rd_in_ready),
  .rd_out_valid(rd_out_valid),
  .rd_out_ready(rd_out_ready),
  .rd_out_data (rd_out_data),
  .rd_out_be   (rd_out_be)
);

// File: tb/byte_fold_codec_tb.sv
module byte_fold_codec_tb;

  localparam int DATA_W = 64;
  localparam int LANES  = DATA_W / 8;
  localparam int N_RAND = 2000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic              chain;
  logic              wr_in_valid;
  logic [DATA_W-1:0] wr_in_data;
  logic [LANES-1:0]  wr_in_be;
  logic              wr_out_ready_drv;
  logic              rd_in_valid_drv;
  logic [DATA_W-1:0] rd_in_data_drv;
  logic [LANES-1:0]  rd_in_be_drv;
  logic              rd_out_ready;

  logic              wr_in_ready, wr_out_valid, wr_out_ready;
  logic [DATA_W-1:0] wr_out_data;
  logic [LANES-1:0]  wr_out_be;
  logic              rd_in_valid, rd_in_ready, rd_out_valid;
  logic [DATA_W-1:0] rd_in_data, rd_out_data;
  logic [LANES-1:0]  rd_in_be, rd_out_be;

  assign rd_in_valid  = chain ? wr_out_valid : rd_in_valid_drv;
  assign rd_in_data   = chain ? wr_out_data  : rd_in_data_drv;
  assign rd_in_be     = chain ? wr_out_be    : rd_in_be_drv;
  assign wr_out_ready = chain ? rd_in_ready  : wr_out_ready_drv;

  byte_fold_codec #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_in_valid(wr_in_valid), .wr_in_ready(wr_in_ready),
    .wr_in_data(wr_in_data), .wr_in_be(wr_in_be),
    .wr_out_valid(wr_out_valid), .wr_out_ready(wr_out_ready),
    .wr_out_data(wr_out_data), .wr_out_be(wr_out_be),
    .rd_in_valid(rd_in_valid), .rd_in_ready(rd_in_ready),
    .rd_in_data(rd_in_data), .rd_in_be(rd_in_be),
    .rd_out_valid(rd_out_valid), .rd_out_ready(rd_out_ready),
    .rd_out_data(rd_out_data), .rd_out_be(rd_out_be)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model written arithmetically, not from the RTL
  function automatic logic [7:0] ref_enc(input logic [7:0] x);
    int m, g;
    m = x[7] ? (255 - int'(x)) : int'(x);
    g = m ^ (m / 2);
    return 8'((g * 2) + (x[7] ? 1 : 0));
  endfunction

  function automatic logic [7:0] ref_dec(input logic [7:0] c);
    for (int v = 0; v < 256; v++) begin
      if (ref_enc(8'(v)) == c) return 8'(v);
    end
    return 8'hxx;
  endfunction

  function automatic logic [63:0] ref_enc_word(input logic [63:0] d, input logic [7:0] be);
    logic [63:0] r;
    for (int i = 0; i < LANES; i++)
      r[i*8 +: 8] = be[i] ? ref_enc(d[i*8 +: 8]) : d[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [63:0] ref_dec_word(input logic [63:0] d, input logic [7:0] be);
    logic [63:0] r;
    for (int i = 0; i < LANES; i++)
      r[i*8 +: 8] = be[i] ? ref_dec(d[i*8 +: 8]) : d[i*8 +: 8];
    return r;
  endfunction

  // Single-word transfers with the output side always ready
  task automatic send_wr(input logic [63:0] d, input logic [7:0] be);
    @(negedge clk);
    wr_in_valid = 1'b1; wr_in_data = d; wr_in_be = be;
    @(posedge clk);
    @(negedge clk);
    wr_in_valid = 1'b0;
  endtask

  task automatic send_rd(input logic [63:0] d, input logic [7:0] be);
    @(negedge clk);
    rd_in_valid_drv = 1'b1; rd_in_data_drv = d; rd_in_be_drv = be;
    @(posedge clk);
    @(negedge clk);
    rd_in_valid_drv = 1'b0;
  endtask

  logic [63:0] exp_q[$];
  logic [7:0]  exp_be_q[$];

  initial begin
    logic [63:0] w, a, b;
    logic [7:0]  be;
    logic [7:0]  ex_in  [8] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'hFF, 8'hFE, 8'hFD, 8'hFC};
    logic [7:0]  ex_out [8] = '{8'h00, 8'h02, 8'h06, 8'h04, 8'h01, 8'h03, 8'h07, 8'h05};
    int sent, got;
    void'($urandom(32'h5EED_0042));
    chain = 1'b0;
    wr_in_valid = 1'b0; wr_in_data = '0; wr_in_be = '0; wr_out_ready_drv = 1'b1;
    rd_in_valid_drv = 1'b0; rd_in_data_drv = '0; rd_in_be_drv = '0; rd_out_ready = 1'b1;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!wr_out_valid && !rd_out_valid, "R9 out valids", {wr_out_valid, rd_out_valid}, 0);
    chk(wr_in_ready && rd_in_ready, "R9 in readies", {wr_in_ready, rd_in_ready}, 2'b11);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 literal mappings, placed in lane 3
    for (int k = 0; k < 8; k++) begin
      send_wr({32'h0, ex_in[k], 24'h0}, 8'hFF);
      chk(wr_out_data[31:24] == ex_out[k], k < 4 ? "R1 example" : "R2 example",
          wr_out_data[31:24], ex_out[k]);
    end

    // R1 R2 R3 R4 R6: every value in every lane, then decode of the codes
    for (int v = 0; v < 256; v++) begin
      for (int i = 0; i < LANES; i++) w[i*8 +: 8] = 8'(v + 32 * i);
      send_wr(w, 8'hFF);
      chk(wr_out_valid, "R6 write latency", wr_out_valid, 1);
      chk(wr_out_data == ref_enc_word(w, 8'hFF), "R4 encode sweep R1/R2",
          wr_out_data, ref_enc_word(w, 8'hFF));
      send_rd(ref_enc_word(w, 8'hFF), 8'hFF);
      chk(rd_out_valid, "R6 read latency", rd_out_valid, 1);
      chk(rd_out_data == w, "R3 decode of encode", rd_out_data, w);
      send_rd(w, 8'hFF);
      chk(rd_out_data == ref_dec_word(w, 8'hFF), "R3 decode sweep",
          rd_out_data, ref_dec_word(w, 8'hFF));
    end

    // R5: random enable masks on both paths
    for (int n = 0; n < 40; n++) begin
      w  = {$urandom, $urandom};
      be = 8'($urandom);
      if (n == 0) be = 8'h00;
      if (n == 1) be = 8'hA5;
      send_wr(w, be);
      chk(wr_out_data == ref_enc_word(w, be), "R5 write masked lanes", wr_out_data, ref_enc_word(w, be));
      chk(wr_out_be == be, "R5 write enables", wr_out_be, be);
      send_rd(w, be);
      chk(rd_out_data == ref_dec_word(w, be), "R5 read masked lanes", rd_out_data, ref_dec_word(w, be));
      chk(rd_out_be == be, "R5 read enables", rd_out_be, be);
    end

    // R7 R8: hold under backpressure, no drop, no duplicate
    a = 64'h0102_FEFF_7F80_0003;
    b = 64'hFC03_81C0_1234_FF00;
    @(negedge clk);
    wr_out_ready_drv = 1'b0;
    send_wr(a, 8'hFF);
    wr_in_valid = 1'b1; wr_in_data = b; wr_in_be = 8'hFF;
    #1;
    chk(!wr_in_ready, "R8 ready low when held", wr_in_ready, 0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(wr_out_valid && wr_out_data == ref_enc_word(a, 8'hFF), "R7 held word",
          wr_out_data, ref_enc_word(a, 8'hFF));
    end
    wr_out_ready_drv = 1'b1;
    #1;
    chk(wr_in_ready, "R8 ready with out_ready", wr_in_ready, 1);
    @(negedge clk);
    wr_in_valid = 1'b0;
    chk(wr_out_valid && wr_out_data == ref_enc_word(b, 8'hFF), "R7 next word not lost",
        wr_out_data, ref_enc_word(b, 8'hFF));
    @(negedge clk);
    chk(!wr_out_valid, "R7 no duplicate", wr_out_valid, 0);

    // R3 R7: chained round trip under random backpressure
    chain = 1'b1;
    sent = 0; got = 0;
    fork
      begin
        logic [63:0] d;
        logic [7:0]  m;
        bit pending = 1'b0;
        while (sent < N_RAND) begin
          @(negedge clk);
          if (!pending) begin
            d = {$urandom, $urandom};
            if ($urandom % 8 == 0) d = {8{8'(($urandom % 2) ? 8'hFF : 8'h01)}};
            m = 8'($urandom);
            pending = ($urandom % 3) != 0;
          end
          wr_in_valid = pending; wr_in_data = d; wr_in_be = m;
          #1;
          if (pending && wr_in_ready) begin
            exp_q.push_back(d);
            exp_be_q.push_back(m);
            sent++;
            pending = 1'b0;
          end
        end
        @(negedge clk);
        wr_in_valid = 1'b0;
      end
      begin
        logic [63:0] e;
        logic [7:0]  em;
        while (got < N_RAND) begin
          @(negedge clk);
          rd_out_ready = ($urandom % 4) != 0;
          #1;
          if (rd_out_valid && rd_out_ready) begin
            e  = exp_q.pop_front();
            em = exp_be_q.pop_front();
            chk(rd_out_data == e && rd_out_be == em, "R3 chained round trip R7",
                rd_out_data, e);
            got++;
          end
        end
      end
    join
    @(negedge clk);
    chk(!rd_out_valid && exp_q.size() == 0, "R7 nothing extra", rd_out_valid, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule